// File: doc/BRIEF.md
# Lockable Transition-Signalling Join Controller

This block is a clocked model of a two-input rendezvous element, a C element, that can be held in a locked state. It is meant to sit in the control path of a stallable pipeline stage. Each of its wires carries events by transition signalling: one event is one change of the wire level, rising or falling. Events on the two join inputs `in_a` and `in_b` are recorded. Once both have been recorded, the block emits one toggle on `out_c` and forgets them. A toggle on `in_lock` asks the block to lock or to unlock. The block answers every such request with exactly one toggle on `out_ack`.

While locked, the block still records join events, but `out_c` is frozen. When the block is unlocked with both events recorded, the held output event is released. If the same join input gets a second event before the output event has been emitted, the second event cancels the first. It is not treated as an error. If the lock handshake is broken, because a new lock request arrives before the previous answer has been emitted, a sticky `choke` flag is raised.

The controller has eight states: `ST_IDLE`, `ST_A`, `ST_B`, `ST_AB`, and the locked copies of these, `ST_LK`, `ST_A_LK`, `ST_B_LK` and `ST_AB_LK`. The transitions are as follows:
- An `a` event moves `ST_IDLE`↔`ST_A` and `ST_B`↔`ST_AB`. The same pairs exist among the locked states.
- A `b` event moves `ST_IDLE`↔`ST_B` and `ST_A`↔`ST_AB`. The same pairs exist among the locked states.
- A lock event moves each unlocked state to its locked copy, and each locked state back to its unlocked copy.
- The fire transition goes from `ST_AB` to `ST_IDLE`. It toggles `out_c` and is taken on a clock that brings no event.

The parameter `START_B` selects the pipeline-stage variant, which comes out of reset in `ST_B`.

Top module: `lockable_join`

## Requirements
- R1: During and right after reset, `out_c`, `out_ack` and `choke` are 0, and the controller is in `ST_IDLE` (when `START_B`=0).
- R2: An `a` event and a `b` event, in either order and any number of clocks apart, produce exactly one `out_c` toggle. The toggle happens on the clock after the second event is taken, provided that clock brings no event. The controller then returns to `ST_IDLE`.
- R3: A second event on the same join input, taken before the output event has been emitted, cancels the first one. The cancelled input does not contribute to an `out_c` toggle.
- R4: In `ST_AB`, an `a` or `b` event taken on the clock where the fire transition would happen cancels that input (to `ST_B` or `ST_A`) instead of firing.
- R5: Every lock event taken produces exactly one `out_ack` toggle, on the clock after the one on which the event was taken.
- R6: In a locked state, `out_c` never toggles. Join events move between locked states exactly as they move between unlocked ones. After an unlock into `ST_AB`, `out_c` toggles on the next event-free clock.
- R7: A lock event taken in `ST_AB` is handled first: the controller goes to `ST_AB_LK` and the output event is deferred.
- R8: Events that are taken on one clock are applied in a fixed order: first `a`, then `b`, then lock.
- R9: A lock event taken on the clock where the previous `out_ack` toggle is still owed sets `choke`. `choke` then stays 1 until reset.
- R10: With `START_B`=1, the controller leaves reset in `ST_B`, so a single `a` event is enough to produce an `out_c` toggle.
- R11: An event is taken on the clock at which the input level differs from the level sampled at the previous clock. This includes the last clock of reset. A held level produces no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_a | input | 1 | Join input A, transition signalled |
| in_b | input | 1 | Join input B, transition signalled |
| in_lock | input | 1 | Lock/unlock request, transition signalled |
| out_c | output | 1 | Join output, toggles once per completed rendezvous |
| out_ack | output | 1 | Lock acknowledge, one toggle per request |
| choke | output | 1 | Sticky handshake-violation flag |

## Verification
The hardest situations to reach from the ports are collisions that fall on the one clock where `ST_AB` would fire. On that clock, a cancelling join event, a lock request, or both together must arrive. A premature lock that lands while an acknowledge is still owed is equally hard to reach. To get there, the bench sweeps every combination of the three event wires over every three-clock sequence from reset, which covers every collision at every depth of the state table. A long random run then follows. Both an arithmetic model, in which each event flips one bit of the state, and the `START_B` variant are driven in lockstep.

// File: rtl/lcj_pkg.sv
package lcj_pkg;
    // Bit 2: locked, bit 1: b recorded, bit 0: a recorded
    typedef enum logic [2:0] {
        ST_IDLE  = 3'b000,
        ST_A     = 3'b001,
        ST_B     = 3'b010,
        ST_AB    = 3'b011,
        ST_LK    = 3'b100,
        ST_A_LK  = 3'b101,
        ST_B_LK  = 3'b110,
        ST_AB_LK = 3'b111
    } lcj_state_e;

    localparam int unsigned LCJ_NUM_EV = 3;
    localparam int unsigned LCJ_EV_A   = 0;
    localparam int unsigned LCJ_EV_B   = 1;
    localparam int unsigned LCJ_EV_L   = 2;
endpackage

// File: rtl/lcj_edge.sv
module lcj_edge #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] ev
);
    logic [N-1:0] ref_q;

    generate
        for (genvar i = 0; i < N; i++) begin : g_det
            // The reference follows the level during reset too, so the first
            // clock out of reset sees no stale event.
            always_ff @(posedge clk) begin
                ref_q[i] <= lvl[i];
            end
            assign ev[i] = rst_n & (lvl[i] ^ ref_q[i]);
        end
    endgenerate
endmodule

// File: rtl/lcj_ctrl.sv
module lcj_ctrl
    import lcj_pkg::*;
#(
    parameter bit START_B = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_a,
    input  logic       ev_b,
    input  logic       ev_l,
    output lcj_state_e st_q,
    output logic       fire,
    output logic       took_lock
);
    localparam lcj_state_e RST_ST = START_B ? ST_B : ST_IDLE;

    lcj_state_e st_d;

    function automatic lcj_state_e take_a(lcj_state_e s);
        lcj_state_e r;
        r = s;
        unique case (s)
            ST_IDLE:  r = ST_A;
            ST_A:     r = ST_IDLE;
            ST_B:     r = ST_AB;
            ST_AB:    r = ST_B;
            ST_LK:    r = ST_A_LK;
            ST_A_LK:  r = ST_LK;
            ST_B_LK:  r = ST_AB_LK;
            ST_AB_LK: r = ST_B_LK;
        endcase
        return r;
    endfunction

    function automatic lcj_state_e take_b(lcj_state_e s);
        lcj_state_e r;
        r = s;
        unique case (s)
            ST_IDLE:  r = ST_B;
            ST_B:     r = ST_IDLE;
            ST_A:     r = ST_AB;
            ST_AB:    r = ST_A;
            ST_LK:    r = ST_B_LK;
            ST_B_LK:  r = ST_LK;
            ST_A_LK:  r = ST_AB_LK;
            ST_AB_LK: r = ST_A_LK;
        endcase
        return r;
    endfunction

    function automatic lcj_state_e take_lock(lcj_state_e s);
        lcj_state_e r;
        r = s;
        unique case (s)
            ST_IDLE:  r = ST_LK;
            ST_A:     r = ST_A_LK;
            ST_B:     r = ST_B_LK;
            ST_AB:    r = ST_AB_LK;
            ST_LK:    r = ST_IDLE;
            ST_A_LK:  r = ST_A;
            ST_B_LK:  r = ST_B;
            ST_AB_LK: r = ST_AB;
        endcase
        return r;
    endfunction

    // Next state: fire only on an event-free clock, else apply a, b, lock in order
    always_comb begin
        lcj_state_e t;
        fire      = (st_q == ST_AB) && !(ev_a || ev_b || ev_l);
        took_lock = ev_l;
        t = st_q;
        if (ev_a) t = take_a(t);
        if (ev_b) t = take_b(t);
        if (ev_l) t = take_lock(t);
        st_d = fire ? ST_IDLE : t;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lcj_out.sv
module lcj_out (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic took_lock,
    output logic c_q,
    output logic ack_q,
    output logic choke_q
);
    logic owe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q     <= 1'b0;
            ack_q   <= 1'b0;
            owe_q   <= 1'b0;
            choke_q <= 1'b0;
        end else begin
            if (fire)  c_q   <= ~c_q;
            if (owe_q) ack_q <= ~ack_q;
            owe_q <= took_lock;
            if (took_lock && owe_q) choke_q <= 1'b1;
        end
    end
endmodule

// File: rtl/lockable_join.sv
module lockable_join
    import lcj_pkg::*;
#(
    parameter bit START_B = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_a,
    input  logic in_b,
    input  logic in_lock,
    output logic out_c,
    output logic out_ack,
    output logic choke
);
    logic [LCJ_NUM_EV-1:0] lvl;
    logic [LCJ_NUM_EV-1:0] ev;
    logic                  ev_a, ev_b, ev_l;
    lcj_state_e            st_q;
    logic                  fire, took_lock;

    assign lvl[LCJ_EV_A] = in_a;
    assign lvl[LCJ_EV_B] = in_b;
    assign lvl[LCJ_EV_L] = in_lock;
    assign ev_a = ev[LCJ_EV_A];
    assign ev_b = ev[LCJ_EV_B];
    assign ev_l = ev[LCJ_EV_L];

    lcj_edge #(.N(LCJ_NUM_EV)) u_edge (
        .clk (clk),
        .rst_n (rst_n),
        .lvl (lvl),
        .ev  (ev)
    );

    lcj_ctrl #(.START_B(START_B)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_a      (ev_a),
        .ev_b      (ev_b),
        .ev_l      (ev_l),
        .st_q      (st_q),
        .fire      (fire),
        .took_lock (took_lock)
    );

    lcj_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .took_lock (took_lock),
        .c_q       (out_c),
        .ack_q     (out_ack),
        .choke_q   (choke)
    );
endmodule

// File: rtl/lcj_chk.sv
module lcj_chk
    import lcj_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       in_lock,
    input logic       out_c,
    input logic       out_ack,
    input logic       choke,
    input lcj_state_e st_q,
    input logic       ev_a,
    input logic       ev_b,
    input logic       ev_l
);
    // R5
    ack_follows_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_lock != $past(in_lock)) |=> ##1 (out_ack != $past(out_ack)));

    // R6
    c_frozen_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q[2] |=> $stable(out_c));

    // R2
    c_only_from_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_c != $past(out_c)) |-> ($past(st_q) == ST_AB));

    // R2
    ab_quiet_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_AB && !ev_a && !ev_b && !ev_l) |=> (out_c != $past(out_c)));

    // R9
    choke_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        choke |=> choke);
endmodule

bind lockable_join lcj_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_lock (in_lock),
    .out_c   (out_c),
    .out_ack (out_ack),
    .choke   (choke),
    .st_q    (st_q),
    .ev_a    (ev_a),
    .ev_b    (ev_b),
    .ev_l    (ev_l)
);

// File: tb/sim_lockable_join.sv
`timescale 1ns/1ps
module sim_lockable_join;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_a = 1'b0, in_b = 1'b0, in_lock = 1'b0;
    logic c0, k0, x0, c1, k1, x1;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    lockable_join #(.START_B(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_lock(in_lock),
        .out_c(c0), .out_ack(k0), .choke(x0));
    lockable_join #(.START_B(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_lock(in_lock),
        .out_c(c1), .out_ack(k1), .choke(x1));

    // Models: state {lock, b, a}; each event flips its bit; firing clears all
    logic [2:0] ms [2];
    logic       mc [2], mk [2], mx [2], mo [2];

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic model_reset();
        ms[0] = 3'b000; ms[1] = 3'b010;
        for (int i = 0; i < 2; i++) begin
            mc[i] = 0; mk[i] = 0; mx[i] = 0; mo[i] = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(c0, 1'b0, "R1 c in reset");
        chk(k0, 1'b0, "R1 ack in reset");
        chk(x0, 1'b0, "R1 choke in reset");
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic cyc(input logic ta, input logic tb, input logic tl, input string tag);
        logic f;
        @(negedge clk);
        if (ta) in_a = ~in_a;
        if (tb) in_b = ~in_b;
        if (tl) in_lock = ~in_lock;
        @(posedge clk);
        #1;
        for (int i = 0; i < 2; i++) begin
            f = (ms[i] == 3'b011) && !(ta || tb || tl);
            if (f) begin
                mc[i] = ~mc[i];
                ms[i] = 3'b000;
            end else begin
                ms[i] = ms[i] ^ {tl, tb, ta};
            end
            if (mo[i]) mk[i] = ~mk[i];
            if (tl && mo[i]) mx[i] = 1'b1;
            mo[i] = tl;
        end
        chk(c0, mc[0], {tag, " u0 c"});
        chk(k0, mk[0], {tag, " u0 ack"});
        chk(x0, mx[0], {tag, " u0 choke"});
        chk(c1, mc[1], {tag, " R10 u1 c"});
        chk(k1, mk[1], {tag, " R10 u1 ack"});
        chk(x1, mx[1], {tag, " R10 u1 choke"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R11: held levels give no event
        cyc(0, 0, 0, "R11"); cyc(0, 0, 0, "R11");
        chk(c0, 1'b0, "R11 no c on held levels");
        // R10: single a fires the pipeline variant
        cyc(1, 0, 0, "R10"); cyc(0, 0, 0, "R10");
        chk(c1, 1'b1, "R10 u1 c after one a");
        chk(c0, 1'b0, "R10 u0 c still waits for b");
        // R2: b completes, fire next quiet clock
        cyc(0, 1, 0, "R2"); cyc(0, 0, 0, "R2");
        chk(c0, 1'b1, "R2 c after a then b");
        // R3: a cancelled by a
        cyc(1, 0, 0, "R3"); cyc(1, 0, 0, "R3"); cyc(0, 1, 0, "R3"); cyc(0, 0, 0, "R3");
        chk(c0, 1'b1, "R3 no c after cancelled a");
        cyc(0, 1, 0, "R3");
        // R4: a on the fire clock cancels a
        cyc(1, 0, 0, "R4"); cyc(0, 1, 0, "R4"); cyc(1, 0, 0, "R4"); cyc(0, 0, 0, "R4");
        chk(c0, 1'b1, "R4 fire cancelled");
        cyc(1, 0, 0, "R4"); cyc(0, 0, 0, "R4");
        chk(c0, 1'b0, "R4 fires after a restored");
        // R5: lock and unlock each acknowledged
        cyc(0, 0, 1, "R5"); cyc(0, 0, 0, "R5");
        chk(k0, 1'b1, "R5 ack for lock");
        cyc(0, 0, 1, "R5"); cyc(0, 0, 0, "R5");
        chk(k0, 1'b0, "R5 ack for unlock");
        // R6: locked, a and b recorded, c frozen, released on unlock
        cyc(0, 0, 1, "R6"); cyc(1, 0, 0, "R6"); cyc(0, 1, 0, "R6");
        cyc(0, 0, 0, "R6"); cyc(0, 0, 0, "R6");
        chk(c0, 1'b0, "R6 c frozen while locked");
        cyc(0, 0, 1, "R6"); cyc(0, 0, 0, "R6");
        chk(c0, 1'b1, "R6 c released after unlock");
        // R7: lock on fire clock defers c
        cyc(1, 0, 0, "R7"); cyc(0, 1, 0, "R7"); cyc(0, 0, 1, "R7"); cyc(0, 0, 0, "R7");
        chk(c0, 1'b1, "R7 c deferred by lock");
        cyc(0, 0, 1, "R7"); cyc(0, 0, 0, "R7");
        chk(c0, 1'b0, "R7 c after unlock");
        // R8: a and b on one clock, then all three from ST_AB
        cyc(1, 1, 0, "R8"); cyc(0, 0, 0, "R8");
        chk(c0, 1'b1, "R8 simultaneous a b fire");
        cyc(1, 0, 0, "R8"); cyc(0, 1, 0, "R8"); cyc(1, 1, 1, "R8"); cyc(0, 0, 0, "R8");
        chk(c0, 1'b1, "R8 all three on fire clock -> idle locked");
        cyc(0, 0, 1, "R8"); cyc(0, 0, 0, "R8");
        // R9: premature lock sets sticky choke
        chk(x0, 1'b0, "R9 choke clear before violation");
        cyc(0, 0, 1, "R9"); cyc(0, 0, 1, "R9");
        chk(x0, 1'b1, "R9 choke raised");
        cyc(0, 0, 0, "R9"); cyc(1, 1, 0, "R9"); cyc(0, 0, 0, "R9");
        chk(x0, 1'b1, "R9 choke sticky");
        do_reset();
        chk(x0, 1'b0, "R9 choke cleared by reset");
        // Sweep: every 3-clock event pattern from reset
        for (int s = 0; s < 512; s++) begin
            do_reset();
            for (int j = 0; j < 3; j++) begin
                logic [2:0] e;
                e = 3'((s >> (3 * j)) & 7);
                cyc(e[0], e[1], e[2], "R4 sweep");
            end
            cyc(0, 0, 0, "R7 sweep"); cyc(0, 0, 0, "R7 sweep");
        end
        // Random run
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            logic [2:0] r;
            r = 3'($urandom_range(0, 7));
            if (($urandom_range(0, 3)) != 0) r[2] = 1'b0;
            cyc(r[0], r[1], r[2], "R5 random");
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule